// File: doc/BRIEF.md
# Serial Register Access Port

This block is a slave serial port that gives a host read and write access to a bank of 8-bit registers. The registers hold the control and status settings of a multi-channel line interface. The host holds the active-low select `cs_n` low for a whole transaction and toggles `sclk`, which idles low. It moves exactly one register per transaction, in a fixed frame of sixteen serial clocks.

The first eight clocks carry the control word: a direction bit, then a 7-bit register address. The last eight clocks carry the data byte. On a write the host drives the byte into `sdi`. On a read the port drives the byte out on `sdo` and raises `sdo_oe`; `sdo_oe` stands in for the tri-state enable of the pad. Every field is sent least significant bit first.

The port runs on the system clock `clk`. It synchronizes `cs_n`, `sclk` and `sdi` and finds the `sclk` edges in that clock domain. For this to work, each `sclk` high phase and each low phase must last at least `SYNC_STAGES + 2` system clocks.

Top module: `lif_serial_regport`

## Requirements
- R1: After reset, every register reads back as 0x00. `sdo_oe` is low after reset and whenever `cs_n` is high.
- R2: The frame order is fixed. Serial clock 1 carries the direction bit. Clocks 2 to 8 carry address bits 0 to 6. Clocks 9 to 16 carry data bits 0 to 7, so each field goes least significant bit first.
- R3: A direction bit of 0 is a write. The eight data bits received in clocks 9 to 16 are stored in the addressed register, and the store happens only when the 16th falling edge arrives.
- R4: A direction bit of 1 is a read. The addressed register's value is captured once the address is complete and is shifted out on `sdo` during clocks 9 to 16, least significant bit first.
- R5: `sdi` is sampled on the falling edge of `sclk`. The level of `sdi` at the rising edge has no effect.
- R6: `sdo` changes only in response to a rising edge of `sclk`. It holds its value through the high phase and across the falling edge.
- R7: `sdo_oe` is high only during a read, from the rising edge of clock 9 to the end of clock 16. It stays low during the control word and during the whole of a write.
- R8: If `cs_n` rises before the 16th falling edge, the transaction is aborted and no register changes. The next transaction starts again at clock 1.
- R9: Serial clocks after the 16th, while `cs_n` stays low, are ignored. They cause no further write and `sdo_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host, idles low |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | High while `sdo` is driven (read data phase) |

## Verification
A change on any serial line reaches the core two system clocks later. Edge detection then adds one more clock, so an `sclk` edge moves `sdo` or `sdo_oe` on the third `clk` edge after the change.

The bench holds each `sclk` phase for eight system clocks. It samples `sdo_oe` and `sdo` five clocks after a rising edge, again at the falling edge and again four clocks after it. This keeps every sample away from the cycles in which those outputs may move.

A write becomes visible only through a later read. The scoreboard therefore predicts each read byte when the frame is issued, and a monitor compares the byte as it is assembled from falling-edge samples. To expose sampling on the wrong edge, `sdi` carries the inverted bit around each rising edge.

// File: rtl/lif_regport_pkg.sv
// Shared types for the serial register port.
// Assumes: nothing beyond IEEE 1800-2017.
package lif_regport_pkg;

    // Direction bit carried first in every frame.
    typedef enum logic {
        XFER_WRITE = 1'b0,
        XFER_READ  = 1'b1
    } xfer_dir_e;

    // Position of the frame engine within one transaction.
    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_DATA = 2'd1,
        PH_DONE = 2'd2
    } frame_phase_e;

endpackage

// File: rtl/lif_bit_sync.sv
// Multi-flop synchronizer that brings one asynchronous line into clk.
// Assumes: STAGES >= 1; RST_VAL is the idle level of the line.
module lif_bit_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] pipe;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/lif_edge_det.sv
// Turns a synchronized level into single-cycle rise and fall strobes.
// Assumes: the input is already in the clk domain and idles at IDLE_VAL.
module lif_edge_det #(
    parameter logic IDLE_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);

    logic lvl_q;

    // Remember the previous level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= IDLE_VAL;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/lif_frame_ctrl.sv
// Frame engine: counts serial edges, collects the control word and the
// write byte on falling edges, shifts read data out on rising edges and
// issues a single write strobe at the end of a complete write frame.
// Assumes: rise/fall/sdi/cs_act are synchronized to clk, and each sclk
// phase spans several clk cycles, so the read-data load (one clk after
// the 8th fall) always precedes the 9th rise.
module lif_frame_ctrl
    import lif_regport_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_oe,
    output frame_phase_e      phase,
    output logic              is_read
);

    localparam int unsigned CW        = ADDR_W + 1;
    localparam int unsigned MAXB      = (CW > DATA_W) ? CW : DATA_W;
    localparam int unsigned CNT_W     = (MAXB > 1) ? $clog2(MAXB) : 1;
    localparam logic [CNT_W-1:0] LAST_CTRL = CNT_W'(CW - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W - 1);

    frame_phase_e      phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CW-1:0]     ctrl_sr;
    logic [DATA_W-1:0] wdat_sr;
    logic [DATA_W-1:0] tx_sr;
    logic              load_q;
    logic              sdo_q;
    logic              oe_q;
    logic              wr_en_q;
    logic [DATA_W-1:0] wr_data_q;

    logic ctrl_last;
    logic data_last;

    assign is_read   = (xfer_dir_e'(ctrl_sr[0]) == XFER_READ);
    assign addr      = ctrl_sr[CW-1:1];
    assign ctrl_last = (phase_q == PH_CTRL) && fall && (cnt_q == LAST_CTRL);
    assign data_last = (phase_q == PH_DATA) && fall && (cnt_q == LAST_DATA);

    // Advance the phase and bit counter on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_CTRL;
            cnt_q   <= '0;
        end else if (!cs_act) begin
            phase_q <= PH_CTRL;
            cnt_q   <= '0;
        end else if (ctrl_last) begin
            phase_q <= PH_DATA;
            cnt_q   <= '0;
        end else if (data_last) begin
            phase_q <= PH_DONE;
            cnt_q   <= '0;
        end else if (fall && phase_q != PH_DONE) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Collect the direction bit and address, least significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_sr <= '0;
        end else if (cs_act && phase_q == PH_CTRL && fall) begin
            ctrl_sr <= {sdi, ctrl_sr[CW-1:1]};
        end
    end

    // Request a one-shot capture of the read value once the address is in.
    always_ff @(posedge clk) begin
        if (!rst_n) load_q <= 1'b0;
        else        load_q <= cs_act && ctrl_last;
    end

    // Collect the write byte, least significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdat_sr <= '0;
        end else if (cs_act && phase_q == PH_DATA && fall) begin
            wdat_sr <= {sdi, wdat_sr[DATA_W-1:1]};
        end
    end

    // Raise the write strobe only when a full write frame has arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_q   <= 1'b0;
            wr_data_q <= '0;
        end else begin
            wr_en_q <= cs_act && data_last && !is_read;
            if (cs_act && data_last) begin
                wr_data_q <= {sdi, wdat_sr[DATA_W-1:1]};
            end
        end
    end

    // Load the read value, then shift it out on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            sdo_q <= 1'b0;
        end else if (!cs_act) begin
            sdo_q <= 1'b0;
        end else if (load_q) begin
            tx_sr <= rd_data;
        end else if (phase_q == PH_DATA && is_read && rise) begin
            sdo_q <= tx_sr[0];
            tx_sr <= {1'b0, tx_sr[DATA_W-1:1]};
        end
    end

    // Enable the output from the first read-data rise to the last fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else if (!cs_act || data_last) begin
            oe_q <= 1'b0;
        end else if (phase_q == PH_DATA && is_read && rise) begin
            oe_q <= 1'b1;
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_data = wr_data_q;
    assign sdo     = sdo_q;
    assign sdo_oe  = oe_q;
    assign phase   = phase_q;

endmodule

// File: rtl/lif_reg_bank.sv
// Register file addressed by the serial port, one write port and one
// asynchronous read port.
// Assumes: depth is 2**ADDR_W; every location resets to zero.
module lif_reg_bank #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the strobed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/lif_serial_regport.sv
// Top of the serial register port: synchronizes the host lines, detects
// serial clock edges, runs the frame engine and holds the register bank.
// Assumes: sclk idles low and each of its phases lasts at least
// SYNC_STAGES + 2 clk cycles; cs_n falls before the first sclk rise.
module lif_serial_regport
    import lif_regport_pkg::*;
#(
    parameter int unsigned ADDR_W      = 7,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);

    logic              cs_n_s;
    logic              sclk_s;
    logic              sdi_s;
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    frame_phase_e      phase;
    logic              is_read;

    // Bring the host lines into clk; cs_n idles high, the others low.
    lif_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_n_s)
    );
    lif_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s)
    );
    lif_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
        .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s)
    );

    assign cs_act = ~cs_n_s;

    lif_edge_det #(.IDLE_VAL(1'b0)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .lvl(sclk_s),
        .rise(sclk_rise), .fall(sclk_fall)
    );

    lif_frame_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act),
        .rise(sclk_rise), .fall(sclk_fall), .sdi(sdi_s),
        .rd_data(rd_data), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .phase(phase), .is_read(is_read)
    );

    lif_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
        .wr_data(wr_data), .rd_addr(addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/lif_serial_regport_chk.sv
// Protocol checker for the serial register port, bound into the top.
// Assumes: signals are sampled on clk with synchronous active-low reset.
module lif_serial_regport_chk
    import lif_regport_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         cs_act,
    input logic         sclk_rise,
    input frame_phase_e phase,
    input logic         is_read,
    input logic         wr_en,
    input logic         sdo,
    input logic         sdo_oe
);

    // Deselect turns the output driver off.
    p_oe_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !sdo_oe);

    // The write strobe appears only at the end of a write frame.
    p_commit_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (phase == PH_DONE && !is_read));

    // Output bit moves only after a rising serial edge.
    p_sdo_rise_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe) && !$past(sclk_rise)) |-> $stable(sdo));

    // Driver enabled only in the data phase of a read.
    p_oe_read_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (phase == PH_DATA && is_read));

    // An aborted frame cannot strobe a write.
    p_no_commit_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !wr_en);

    // One frame yields at most one write strobe.
    p_single_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

endmodule

bind lif_serial_regport lif_serial_regport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sclk_rise(sclk_rise),
    .phase(phase), .is_read(is_read), .wr_en(wr_en),
    .sdo(sdo), .sdo_oe(sdo_oe)
);

// File: tb/lif_serial_regport_test.sv
// Scoreboard bench: the frame driver predicts read bytes into a queue, a
// monitor assembles bytes from sdo at falling sclk edges and compares.
module lif_serial_regport_test;

    localparam int HP = 8;   // sclk half period in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] model [128];
    logic [7:0] exp_q [$];
    logic [7:0] mon_byte = '0;
    int         mon_n = 0;

    always #10 clk = ~clk;   // 50 MHz

    lif_serial_regport uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic check(input bit ok, input string req,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of nbits serial clocks; bits past 16 are sent as ones.
    task automatic xfer(input bit is_rd, input logic [6:0] a,
                        input logic [7:0] d, input int nbits);
        logic [15:0] fr;
        fr = {d, a, is_rd};
        if (is_rd && nbits >= 16) exp_q.push_back(model[a]);
        cs_n = 1'b0;
        idle(4);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            logic s1, s2, s3;
            bit   exp_oe;
            b = (i < 16) ? fr[i] : 1'b1;
            exp_oe = is_rd && (i >= 8) && (i < 16);
            sdi  = ~b;             // wrong level at the rising edge (R5)
            sclk = 1'b1;
            idle(4);
            sdi = b;
            idle(1);
            // R7 enable window; R9 keeps it low after bit 16
            check(sdo_oe == exp_oe, (i >= 16) ? "R9 oe" : "R7 oe",
                  sdo_oe, exp_oe);
            s1 = sdo;
            idle(HP - 5);
            sclk = 1'b0;
            s2 = sdo;
            idle(4);
            sdi = ~b;
            s3 = sdo;
            idle(HP - 4);
            if (exp_oe) check(s1 == s2 && s2 == s3, "R6 sdo stable",
                              {s1, s2, s3}, {s1, s1, s1});
        end
        idle(HP);
        cs_n = 1'b1;
        idle(HP);
        check(sdo_oe == 1'b0, "R1 oe off after deselect", sdo_oe, 0);
        if (!is_rd && nbits >= 16) model[a] = d;
    endtask

    // Monitor: gather read bits at falling sclk edges, compare per byte (R4).
    always @(negedge sclk) begin
        if (sdo_oe && !cs_n) begin
            mon_byte[mon_n] = sdo;
            mon_n++;
            if (mon_n == 8) begin
                mon_n = 0;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected read byte", mon_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(mon_byte == e, "R4/R2/R5 read byte", mon_byte, e);
                end
            end
        end
    end

    always @(posedge cs_n) mon_n = 0;

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        idle(5);
        rst_n = 1'b1;
        idle(2);
        check(sdo_oe == 1'b0, "R1 oe after reset", sdo_oe, 0);

        // R1: reset contents
        xfer(1'b1, 7'h00, 8'h00, 16);
        xfer(1'b1, 7'h05, 8'h00, 16);
        xfer(1'b1, 7'h7F, 8'h00, 16);

        // R3/R2: writes covering distinct address and data bit patterns
        xfer(1'b0, 7'h05, 8'hA5, 16);
        xfer(1'b0, 7'h7F, 8'h3C, 16);
        xfer(1'b0, 7'h00, 8'h81, 16);
        xfer(1'b0, 7'h40, 8'h01, 16);
        for (int k = 0; k < 6; k++) begin
            xfer(1'b0, 7'(8'h11 * k + 8'h08), 8'(8'h37 * k + 8'h1D), 16);
        end

        // R4: read back, plus untouched neighbours
        xfer(1'b1, 7'h05, 8'h00, 16);
        xfer(1'b1, 7'h7F, 8'h00, 16);
        xfer(1'b1, 7'h00, 8'h00, 16);
        xfer(1'b1, 7'h40, 8'h00, 16);
        xfer(1'b1, 7'h41, 8'h00, 16);
        xfer(1'b1, 7'h04, 8'h00, 16);
        for (int k = 0; k < 6; k++) begin
            xfer(1'b1, 7'(8'h11 * k + 8'h08), 8'h00, 16);
        end

        // R8: aborted writes change nothing; next frame restarts cleanly
        xfer(1'b0, 7'h05, 8'hFF, 12);
        xfer(1'b0, 7'h7F, 8'h00, 3);
        xfer(1'b0, 7'h00, 8'h7E, 15);
        xfer(1'b1, 7'h05, 8'h00, 16);
        xfer(1'b1, 7'h7F, 8'h00, 16);
        xfer(1'b1, 7'h00, 8'h00, 16);

        // R8: aborted read yields no byte, the next read is whole
        xfer(1'b1, 7'h40, 8'h00, 11);
        xfer(1'b1, 7'h40, 8'h00, 16);

        // R9: extra clocks after a full frame are ignored
        xfer(1'b0, 7'h10, 8'h5A, 20);
        xfer(1'b1, 7'h10, 8'h00, 20);
        xfer(1'b1, 7'h7F, 8'h00, 16);

        idle(4);
        check(exp_q.size() == 0, "R4 all predicted bytes seen",
              exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule